// File: doc/BRIEF.md
# 8-bit ALU with Processor Status Register

This block is the arithmetic core of a small accumulator machine. Each request carries an operation code, a register value and an operand. The block computes an 8-bit result and applies the operation's flag effects to a status register that it holds internally. The supported operations are:

- add and subtract through the carry, in binary or packed decimal;
- the three bitwise logic operations;
- bit test;
- four shift and rotate forms;
- compare;
- single-flag set and clear commands;
- saving the status byte (push) and restoring it (pull).

Requests enter on a valid/ready port. When `in_valid` and `in_ready` are both high on a rising edge, the request is accepted. In that same edge the result goes into a one-entry output slot and the status register updates. The slot raises `out_valid` and holds its contents until `out_ready` is high on an edge. `in_ready` is high whenever the slot is empty or is being drained in the same cycle. So one operation per cycle can flow when the consumer always accepts, and a stalled consumer stalls the producer without losing data. `status_o` always shows the live status byte.

Top module: `alu8_core`

## Requirements
- R1: The status byte puts N at bit 7, V at bit 6, a constant 1 at bit 5, B at bit 4, D at bit 3, I at bit 2, Z at bit 1 and C at bit 0. B reads 0 in `status_o` and `out_flags`. After reset the live status is 0x24: only I and bit 5 are set.
- R2: Opcode 0 (add) and opcode 1 (subtract) use C as the carry in. Subtract adds the inverted operand, so C=1 means no borrow. The sum is written. In binary mode C is the carry out. N is bit 7 of the sum. Z is set when the sum is zero. V is set on signed overflow.
- R3: With D=1, add and subtract work on two packed decimal digits. A digit sum above 9 is corrected by +6 and carries into the next digit. A negative digit difference is corrected by -6 and borrows. C comes from the decimal carry or borrow. N, V and Z are taken from the binary sum.
- R4: Opcodes 2 (AND), 3 (OR) and 4 (XOR) write the result and change only N and Z.
- R5: Bit test (opcode 5) copies operand bits 7 and 6 into N and V. It sets Z when register AND operand is zero. It leaves C unchanged and writes nothing back: `out_write` is 0 and `out_result` equals `in_a`.
- R6: Opcodes 6 (shift left), 7 (logical shift right), 8 (rotate left through C) and 9 (rotate right through C) write the result. They put the bit shifted out into C and update N and Z.
- R7: Compare (opcode 10) sets C when `in_a` >= `in_b` unsigned, sets Z on equality and sets N to bit 7 of the difference. It writes nothing back.
- R8: Opcode 11 is a flag command selected by `in_b[2:0]`: 0 clears C, 1 sets C, 2 clears I, 3 sets I, 4 clears D, 5 sets D, 6 clears V, 7 does nothing. It writes nothing back.
- R9: Push (opcode 12) writes the current status byte with bit 5 = 1 and with bit 4 = `in_b[4]`. The flags are not changed.
- R10: Pull (opcode 13) loads N, V, D, I, Z and C from `in_b` bits 7, 6, 3, 2, 1 and 0. Operand bits 5 and 4 are ignored.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result, the write flag and the flags stay stable. The status changes only on an accepted request.
- R12: Opcodes 14 and 15 change no flag, have `out_write` = 0 and return `in_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 8 | Register value (accumulator or index) |
| in_b | input | 8 | Operand |
| out_valid | output | 1 | Output slot holds a result |
| out_ready | input | 1 | Consumer takes the slot this cycle |
| out_result | output | 8 | Result byte |
| out_write | output | 1 | Result is meant to be written back |
| out_flags | output | 8 | Status byte after the operation |
| status_o | output | 8 | Live status byte |

## Verification
Add and subtract are driven with hand-picked pairs, which separate the cases below:

- signed overflow with no carry, and carry with no overflow;
- a borrow, and a zero result;
- in decimal mode, single-digit and two-digit corrections, including the wrap to zero that must set C.

Long random streams then mix every opcode over random operands and a random carry and decimal state. These streams show whether each operation touches only its own flags, since a wrong flag persists and corrupts later results.

A stalled consumer with a second request waiting separates a correct hold-and-release from a slot that drops or overwrites data. Pushes with both break values and pulls with bits 5 and 4 set tell the fixed bits apart from the stored ones.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW   = 8;
  localparam int NDIG = DW / 4;
  localparam int OPW  = 4;

  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_I = 2;
  localparam int SB_D = 3;
  localparam int SB_B = 4;
  localparam int SB_U = 5;
  localparam int SB_V = 6;
  localparam int SB_N = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_BIT  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_CMP  = 4'd10,
    OP_FLAG = 4'd11,
    OP_PUSH = 4'd12,
    OP_PULL = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  function automatic logic [DW-1:0] pack_status(input flags_t f, input logic brk);
    logic [DW-1:0] s;
    s       = '0;
    s[SB_N] = f.n;
    s[SB_V] = f.v;
    s[SB_U] = 1'b1;
    s[SB_B] = brk;
    s[SB_D] = f.d;
    s[SB_I] = f.i;
    s[SB_Z] = f.z;
    s[SB_C] = f.c;
    return s;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          cin_i,
  input  logic          dec_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          v_o,
  output logic          z_o,
  output logic          c_o
);
  logic [DW-1:0] bx;
  logic [DW:0]   bin_sum;
  logic [DW-1:0] dec_res;
  logic          dec_c;

  always_comb begin
    bx      = sub_i ? ~b_i : b_i;
    bin_sum = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, cin_i};
    n_o     = bin_sum[DW-1];
    z_o     = (bin_sum[DW-1:0] == '0);
    v_o     = (a_i[DW-1] == bx[DW-1]) && (bin_sum[DW-1] != a_i[DW-1]);
  end

  // digit-serial decimal correction, one nibble per loop step
  always_comb begin
    logic [5:0] dsum;
    logic       link;
    dec_res = '0;
    link    = sub_i ? ~cin_i : cin_i;
    for (int k = 0; k < NDIG; k++) begin
      if (!sub_i) begin
        dsum = {2'b00, a_i[4*k +: 4]} + {2'b00, b_i[4*k +: 4]} + {5'd0, link};
        link = (dsum > 6'd9);
        if (link) dsum = dsum + 6'd6;
      end else begin
        dsum = {2'b00, a_i[4*k +: 4]} - {2'b00, b_i[4*k +: 4]} - {5'd0, link};
        link = dsum[5];
        if (link) dsum = dsum - 6'd6;
      end
      dec_res[4*k +: 4] = dsum[3:0];
    end
    dec_c = sub_i ? ~link : link;
  end

  assign res_o = dec_i ? dec_res : bin_sum[DW-1:0];
  assign c_o   = dec_i ? dec_c   : bin_sum[DW];

  // binary add with no carry in and no carry out cannot shrink the value
  always_comb begin
    if (!dec_i && !sub_i && !cin_i && !c_o)
      p_add_nowrap_r2: assert (res_o >= a_i) else $error("binary add wrapped without carry");
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          z_o,
  output logic          c_o
);
  logic [DW:0] diff;

  always_comb begin
    diff  = {1'b0, a_i} - {1'b0, b_i};
    res_o = a_i;
    c_o   = cin_i;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_BIT:  res_o = a_i & b_i;
      OP_SHL:  begin res_o = {a_i[DW-2:0], 1'b0};  c_o = a_i[DW-1]; end
      OP_SHR:  begin res_o = {1'b0, a_i[DW-1:1]};  c_o = a_i[0];    end
      OP_ROL:  begin res_o = {a_i[DW-2:0], cin_i}; c_o = a_i[DW-1]; end
      OP_ROR:  begin res_o = {cin_i, a_i[DW-1:1]}; c_o = a_i[0];    end
      OP_CMP:  begin res_o = diff[DW-1:0];         c_o = ~diff[DW]; end
      default: res_o = a_i;
    endcase
    n_o = res_o[DW-1];
    z_o = (res_o == '0);
  end

  always_comb begin
    if (op_i == OP_CMP && z_o)
      p_cmp_eq_carry_r7: assert (c_o) else $error("compare equal without carry");
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_i,
  input  flags_t next_i,
  output flags_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};
    else if (upd_i) q_o <= next_i;
  end

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(q_o)) else $error("status moved without an accepted request");
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_write,
  output logic [DW-1:0] out_flags,
  output logic [DW-1:0] status_o
);
  op_e           op;
  flags_t        st_q;
  flags_t        nf;
  logic          accept;
  logic [DW-1:0] ar_res, lg_res, res;
  logic          ar_n, ar_v, ar_z, ar_c;
  logic          lg_n, lg_z, lg_c;
  logic          wr;

  assign op       = op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  alu8_arith u_arith (
    .a_i   (in_a),
    .b_i   (in_b),
    .sub_i (op == OP_SUB),
    .cin_i (st_q.c),
    .dec_i (st_q.d),
    .res_o (ar_res),
    .n_o   (ar_n),
    .v_o   (ar_v),
    .z_o   (ar_z),
    .c_o   (ar_c)
  );

  alu8_logic u_logic (
    .op_i  (op),
    .a_i   (in_a),
    .b_i   (in_b),
    .cin_i (st_q.c),
    .res_o (lg_res),
    .n_o   (lg_n),
    .z_o   (lg_z),
    .c_o   (lg_c)
  );

  // per-operation flag merge
  always_comb begin
    nf  = st_q;
    res = in_a;
    wr  = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res = ar_res; wr = 1'b1;
        nf.n = ar_n; nf.v = ar_v; nf.z = ar_z; nf.c = ar_c;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res = lg_res; wr = 1'b1;
        nf.n = lg_n; nf.z = lg_z;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res = lg_res; wr = 1'b1;
        nf.n = lg_n; nf.z = lg_z; nf.c = lg_c;
      end
      OP_BIT: begin
        nf.n = in_b[DW-1]; nf.v = in_b[DW-2]; nf.z = lg_z;
      end
      OP_CMP: begin
        nf.n = lg_n; nf.z = lg_z; nf.c = lg_c;
      end
      OP_FLAG: begin
        unique case (in_b[2:0])
          3'd0: nf.c = 1'b0;
          3'd1: nf.c = 1'b1;
          3'd2: nf.i = 1'b0;
          3'd3: nf.i = 1'b1;
          3'd4: nf.d = 1'b0;
          3'd5: nf.d = 1'b1;
          3'd6: nf.v = 1'b0;
          default: ;
        endcase
      end
      OP_PUSH: begin
        res = pack_status(st_q, in_b[SB_B]); wr = 1'b1;
      end
      OP_PULL: begin
        nf.n = in_b[SB_N]; nf.v = in_b[SB_V]; nf.d = in_b[SB_D];
        nf.i = in_b[SB_I]; nf.z = in_b[SB_Z]; nf.c = in_b[SB_C];
      end
      default: ;
    endcase
  end

  alu8_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (accept),
    .next_i (nf),
    .q_o    (st_q)
  );

  // one-entry output slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_write  <= 1'b0;
      out_flags  <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= res;
      out_write  <= wr;
      out_flags  <= pack_status(nf, 1'b0);
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assign status_o = pack_status(st_q, 1'b0);

  p_slot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_write))
    else $error("output slot changed under back-pressure");

  p_logic_keeps_cv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_AND || op == OP_OR || op == OP_XOR)
      |=> status_o[SB_C] == $past(status_o[SB_C]) && status_o[SB_V] == $past(status_o[SB_V]))
    else $error("logic op changed C or V");

  p_bit_keeps_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_BIT |=> status_o[SB_C] == $past(status_o[SB_C]) && !out_write)
    else $error("bit test changed C or wrote");

  p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_CMP |=> out_valid && !out_write)
    else $error("compare wrote a result");

  p_push_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_PUSH |=> $stable(status_o) && out_result[SB_U])
    else $error("push altered status or lost bit 5");
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic       out_write;
  logic [7:0] out_flags;
  logic [7:0] status_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] mflags = 8'h24;

  always #2.5 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_write(out_write),
    .out_flags(out_flags), .status_o(status_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic string req_of(input logic [3:0] op);
    case (op)
      0, 1:    return "R2/R3";
      2, 3, 4: return "R4";
      5:       return "R5";
      6, 7, 8, 9: return "R6";
      10:      return "R7";
      11:      return "R8";
      12:      return "R9";
      13:      return "R10";
      default: return "R12";
    endcase
  endfunction

  // returns {write, result, flags}
  function automatic logic [16:0] ref_model(input logic [3:0] op, input logic [7:0] a,
                                            input logic [7:0] b, input logic [7:0] f);
    logic n, v, d, i, z, c, wr, k;
    logic [7:0] r, bb, bin, lo8, hi8;
    int s, lo, hi;
    n = f[7]; v = f[6]; d = f[3]; i = f[2]; z = f[1]; c = f[0];
    r = a; wr = 0;
    case (op)
      0, 1: begin
        bb  = (op == 1) ? ~b : b;
        s   = int'(a) + int'(bb) + int'(c);
        bin = s[7:0];
        v   = (a[7] == bb[7]) && (bin[7] != a[7]);
        n   = bin[7]; z = (bin == 0); wr = 1;
        if (!d) begin
          r = bin; c = (s > 255);
        end else if (op == 0) begin
          lo = int'(a[3:0]) + int'(b[3:0]) + int'(c);
          k  = (lo > 9); if (k) lo += 6;
          hi = int'(a[7:4]) + int'(b[7:4]) + int'(k);
          c  = (hi > 9); if (c) hi += 6;
          lo8 = lo[7:0]; hi8 = hi[7:0]; r = {hi8[3:0], lo8[3:0]};
        end else begin
          lo = int'(a[3:0]) - int'(b[3:0]) - (1 - int'(c));
          k  = (lo < 0); if (k) lo -= 6;
          hi = int'(a[7:4]) - int'(b[7:4]) - int'(k);
          c  = !(hi < 0); if (hi < 0) hi -= 6;
          lo8 = lo[7:0]; hi8 = hi[7:0]; r = {hi8[3:0], lo8[3:0]};
        end
      end
      2: begin r = a & b; n = r[7]; z = (r == 0); wr = 1; end
      3: begin r = a | b; n = r[7]; z = (r == 0); wr = 1; end
      4: begin r = a ^ b; n = r[7]; z = (r == 0); wr = 1; end
      5: begin n = b[7]; v = b[6]; z = ((a & b) == 0); end
      6: begin r = a << 1; c = a[7]; n = r[7]; z = (r == 0); wr = 1; end
      7: begin r = a >> 1; c = a[0]; n = r[7]; z = (r == 0); wr = 1; end
      8: begin r = {a[6:0], c}; c = a[7]; n = r[7]; z = (r == 0); wr = 1; end
      9: begin r = {c, a[7:1]}; c = a[0]; n = r[7]; z = (r == 0); wr = 1; end
      10: begin bin = a - b; c = (a >= b); z = (a == b); n = bin[7]; end
      11: case (b[2:0])
            0: c = 0; 1: c = 1; 2: i = 0; 3: i = 1;
            4: d = 0; 5: d = 1; 6: v = 0; default: ;
          endcase
      12: begin r = {n, v, 1'b1, b[4], d, i, z, c}; wr = 1; end
      13: begin n = b[7]; v = b[6]; d = b[3]; i = b[2]; z = b[1]; c = b[0]; end
      default: ;
    endcase
    return {wr, r, n, v, 1'b1, 1'b0, d, i, z, c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [16:0] e;
    e = ref_model(op, a, b, mflags);
    @(negedge clk);
    in_valid = 1; in_op = op; in_a = a; in_b = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    mflags = e[7:0];
    check(req_of(op), {6'd0, out_valid, out_write, out_result, out_flags, status_o},
          {6'd0, 1'b1, e[16], e[15:8], e[7:0], e[7:0]});
  endtask

  initial begin
    logic [7:0] held_r, held_s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset status", {24'd0, status_o}, 32'h24);
    check("R11 reset ready", {30'd0, out_valid, in_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);

    // R2 binary corners
    do_op(11, 0, 0);          // clear C
    do_op(0, 8'h50, 8'h50);   // signed overflow, no carry
    do_op(11, 0, 0);
    do_op(0, 8'hFF, 8'h01);   // carry out, zero
    do_op(0, 8'h7F, 8'h00);   // carry in used
    do_op(11, 0, 1);          // set C
    do_op(1, 8'h05, 8'h06);   // borrow
    do_op(11, 0, 1);
    do_op(1, 8'h80, 8'h01);   // signed overflow on subtract
    // R3 decimal
    do_op(11, 0, 5);          // set D
    do_op(11, 0, 0);
    do_op(0, 8'h15, 8'h27);   // 42
    do_op(11, 0, 0);
    do_op(0, 8'h99, 8'h01);   // 00 carry
    do_op(11, 0, 1);
    do_op(1, 8'h42, 8'h15);   // 27
    do_op(11, 0, 1);
    do_op(1, 8'h00, 8'h01);   // 99 borrow
    do_op(11, 0, 4);          // clear D
    // R4 to R10, R12 directed
    do_op(2, 8'hF0, 8'h0F);
    do_op(3, 8'h80, 8'h01);
    do_op(4, 8'hAA, 8'hAA);
    do_op(5, 8'h01, 8'hC2);
    do_op(6, 8'h81, 0); do_op(7, 8'h01, 0); do_op(8, 8'h80, 0); do_op(9, 8'h01, 0);
    do_op(10, 8'h40, 8'h40); do_op(10, 8'h10, 8'h20); do_op(10, 8'h20, 8'h10);
    do_op(11, 0, 3); do_op(11, 0, 2); do_op(11, 0, 6); do_op(11, 0, 7);
    do_op(12, 0, 8'h10); do_op(12, 0, 8'h00);
    do_op(13, 0, 8'h30); do_op(13, 0, 8'hCF);
    do_op(14, 8'h5A, 8'hFF); do_op(15, 8'hA5, 8'h00);

    // R11 back-pressure
    @(negedge clk);
    out_ready = 0;
    do_op(2, 8'h3C, 8'h0F);
    check("R11 ready low while full", {31'd0, in_ready}, 32'd0);
    held_r = out_result; held_s = status_o;
    in_valid = 1; in_op = 4'd3; in_a = 8'h01; in_b = 8'h80;
    repeat (3) @(negedge clk);
    check("R11 slot held", {16'd0, out_result, status_o}, {16'd0, held_r, held_s});
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    mflags = ref_model(3, 8'h01, 8'h80, mflags) >> 0;
    check("R11 released", {24'd0, out_result}, 32'h81);
    mflags = ref_model(3, 8'h01, 8'h80, held_s);
    mflags = mflags;

    // random mix
    for (int t = 0; t < 600; t++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      do_op(op, 8'($urandom), 8'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule